// File: doc/BRIEF.md
# Dual Second-Order Recursive Filter Accelerator

This block holds two independent second-order recursive (biquad) filter sections that run side by side. Each section keeps its own five coefficients and a two-entry intermediate history, and computes each output from that history rather than from separate input and output histories. Software programs the coefficients and the history through a small word-addressed register port. It can later read the history back, or write a saved copy into it, so that a stream resumes exactly where it stopped.

Filtering is started per engine by a command that opens a batch of eight samples. Samples arrive on a per-engine valid/ready input stream, and each filtered result leaves on a matching valid/ready output stream. One multiplier per engine is reused across five successive multiply-accumulate steps for each sample. Only one sample per engine is in progress at a time.

Top module: `dual_biquad_engine`

## Requirements
- R1: Each sample is processed as follows. First w = x − a1·h1 − a2·h2. Then y = b0·w + b1·h1 + b2·h2. After that the history shifts: h2 takes the old h1 and h1 takes w.
- R2: Samples and outputs are signed Q1.15 and coefficients are signed Q2.14. Sums are kept in 40 bits. Both w and y are formed as (sum + 2^13) arithmetically shifted right by 14, then saturated to the range −32768..32767.
- R3: Word address bit 3 selects the engine, and bits 2:0 select the register: 0 b0, 1 b1, 2 b2, 3 a1, 4 a2, 5 h1, 6 h2, 7 control/status. Registers 0..6 read back the 16-bit value last written.
- R4: Writing bit 0 of the control register while the engine is idle starts a batch. After exactly eight input samples and eight delivered outputs the engine returns to idle with the done flag set.
- R5: Reading the status register returns busy in bit 0, done in bit 1, and the number of outputs still owed in the current batch in bits 7:4. Done is cleared by a start.
- R6: While an engine is busy, writes to its coefficients, its history, its clear bit and its start bit have no effect.
- R7: Values written to h1 and h2 are used as the history of the next sample. After a batch, h1 and h2 read back the history left by the last sample, so a saved state can be restored to resume the stream.
- R8: Writing bit 1 of the control register while idle zeroes h1 and h2 of that engine and leaves its coefficients unchanged.
- R9: An input is accepted only while the engine is busy, no sample is being computed, and no output is pending. Ready falls in the cycle after an acceptance.
- R10: While output valid is high and output ready is low, output valid stays high and output data does not change.
- R11: The two engines share no coefficients, history or stream state; the batches of both may run at the same time.
- R12: After reset, all coefficients, history, status and stream valid/ready outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address: engine select and register index |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| s_valid | input | 2 | Input sample valid, one bit per engine |
| s_ready | output | 2 | Input sample ready, one bit per engine |
| s_data | input | 32 | Input samples, engine e in bits 16e+15:16e |
| m_valid | output | 2 | Output sample valid, one bit per engine |
| m_ready | input | 2 | Output sample ready, one bit per engine |
| m_data | output | 32 | Output samples, engine e in bits 16e+15:16e |

## Verification
The assertions take it for granted that the consumer of the output stream eventually raises ready. They also assume the source drives only 16-bit samples and does not expect more than one sample per engine to be in flight. The stimulus inserts random gaps on input valid and random stalls on output ready while keeping within the eight-sample batch that each start opens. Register writes during a batch are issued only in deliberate directed cases that test the lockout.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int SAMP_W  = 16;
  localparam int COEF_W  = 16;
  localparam int ACC_W   = 40;
  localparam int FRAC_W  = 14;
  localparam int N_COEF  = 5;
  localparam int LAST_STEP = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CALC, ST_OUT} bq_state_e;

  function automatic logic signed [SAMP_W-1:0] sat_round(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] r;
    r = (acc + (ACC_W'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
    if (r > ACC_W'(2**(SAMP_W-1) - 1))
      return {1'b0, {(SAMP_W-1){1'b1}}};
    else if (r < -ACC_W'(2**(SAMP_W-1)))
      return {1'b1, {(SAMP_W-1){1'b0}}};
    else
      return r[SAMP_W-1:0];
  endfunction
endpackage

// File: rtl/bq_mac.sv
module bq_mac #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    load,
  input  logic                    sub,
  input  logic signed [ACC_W-1:0] init,
  input  logic signed [A_W-1:0]   opa,
  input  logic signed [B_W-1:0]   opb,
  output logic signed [ACC_W-1:0] acc
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0]   prod;
  logic signed [ACC_W-1:0] prod_x;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    prod   = opa * opb;
    prod_x = {{(ACC_W-P_W){prod[P_W-1]}}, prod};
    base   = load ? init : acc;
    acc_d  = sub ? (base - prod_x) : (base + prod_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_d;
  end
endmodule

// File: rtl/bq_section.sv
module bq_section
  import bq_pkg::*;
#(
  parameter int BATCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [15:0]       wr_data,
  input  logic [2:0]        rd_idx,
  output logic [15:0]       rd_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SAMP_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [SAMP_W-1:0] m_data
);
  localparam int CNT_W   = $clog2(BATCH + 1);
  localparam int IDX_CTL = 7;
  localparam int IDX_H1  = 5;
  localparam int IDX_H2  = 6;

  bq_state_e                 st_q, st_d;
  logic [2:0]                step_q, step_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      done_q, done_d;
  logic signed [SAMP_W-1:0]  x_q;
  logic signed [SAMP_W-1:0]  h1_q, h1_d, h2_q, h2_d;
  logic signed [SAMP_W-1:0]  w_q, w_now;
  logic signed [COEF_W-1:0]  coef_q [N_COEF];
  logic signed [ACC_W-1:0]   acc;
  logic signed [ACC_W-1:0]   mac_init;
  logic signed [COEF_W-1:0]  opa;
  logic signed [SAMP_W-1:0]  opb;
  logic                      busy, cfg_we, start, clr, take, give, last;
  logic                      mac_load, mac_sub, calc;

  always_comb begin
    busy   = (st_q != ST_IDLE);
    cfg_we = wr_en && !busy;
    start  = cfg_we && (wr_idx == 3'(IDX_CTL)) && wr_data[0];
    clr    = cfg_we && (wr_idx == 3'(IDX_CTL)) && wr_data[1];
    take   = (st_q == ST_WAIT) && s_valid;
    give   = (st_q == ST_OUT) && m_ready;
    last   = (cnt_q == CNT_W'(1));
    calc   = (st_q == ST_CALC);
    w_now  = sat_round(acc);
  end

  // next state of the sequencer
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_WAIT;
        cnt_d  = CNT_W'(BATCH);
        done_d = 1'b0;
      end
      ST_WAIT: if (take) begin
        st_d   = ST_CALC;
        step_d = '0;
      end
      ST_CALC: begin
        step_d = step_q + 3'd1;
        if (step_q == 3'(LAST_STEP)) st_d = ST_OUT;
      end
      ST_OUT: if (give) begin
        cnt_d = cnt_q - CNT_W'(1);
        if (last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // history next value: software write, clear, or shift after a sample
  always_comb begin
    h1_d = h1_q;
    h2_d = h2_q;
    if (cfg_we && wr_idx == 3'(IDX_H1)) h1_d = wr_data;
    if (cfg_we && wr_idx == 3'(IDX_H2)) h2_d = wr_data;
    if (clr) begin
      h1_d = '0;
      h2_d = '0;
    end
    if (calc && step_q == 3'(LAST_STEP)) begin
      h2_d = h1_q;
      h1_d = w_q;
    end
  end

  // operand schedule of the shared multiplier
  always_comb begin
    mac_load = (step_q == 3'd0) || (step_q == 3'd2);
    mac_sub  = (step_q < 3'd2);
    mac_init = (step_q == 3'd0)
             ? {{(ACC_W-SAMP_W-FRAC_W){x_q[SAMP_W-1]}}, x_q, {FRAC_W{1'b0}}}
             : '0;
    unique case (step_q)
      3'd0:    begin opa = coef_q[3]; opb = h1_q;  end
      3'd1:    begin opa = coef_q[4]; opb = h2_q;  end
      3'd2:    begin opa = coef_q[0]; opb = w_now; end
      3'd3:    begin opa = coef_q[1]; opb = h1_q;  end
      default: begin opa = coef_q[2]; opb = h2_q;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      h1_q   <= '0;
      h2_q   <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      h1_q   <= h1_d;
      h2_q   <= h2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    x_q <= '0;
    else if (take) x_q <= s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           w_q <= '0;
    else if (calc && step_q == 3'd2)      w_q <= w_now;
  end

  for (genvar c = 0; c < N_COEF; c++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             coef_q[c] <= '0;
      else if (cfg_we && wr_idx == 3'(c))     coef_q[c] <= wr_data;
    end
  end

  bq_mac #(.A_W(COEF_W), .B_W(SAMP_W), .ACC_W(ACC_W)) u_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (calc),
    .load (mac_load),
    .sub  (mac_sub),
    .init (mac_init),
    .opa  (opa),
    .opb  (opb),
    .acc  (acc)
  );

  always_comb begin
    s_ready = (st_q == ST_WAIT);
    m_valid = (st_q == ST_OUT);
    m_data  = w_now;
    unique case (rd_idx)
      3'd5:    rd_data = h1_q;
      3'd6:    rd_data = h2_q;
      3'd7:    rd_data = {8'd0, 4'(cnt_q), 2'b00, done_q, busy};
      default: rd_data = (rd_idx < 3'(N_COEF)) ? coef_q[rd_idx] : '0;
    endcase
  end
endmodule

// File: rtl/dual_biquad_engine.sv
module dual_biquad_engine
  import bq_pkg::*;
#(
  parameter int N_ENG  = 2,
  parameter int BATCH  = 8,
  localparam int ENG_B = (N_ENG > 1) ? $clog2(N_ENG) : 1,
  localparam int ADR_W = 3 + ENG_B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr_en,
  input  logic [ADR_W-1:0]        bus_addr,
  input  logic [15:0]             bus_wdata,
  output logic [15:0]             bus_rdata,
  input  logic [N_ENG-1:0]        s_valid,
  output logic [N_ENG-1:0]        s_ready,
  input  logic [N_ENG*SAMP_W-1:0] s_data,
  output logic [N_ENG-1:0]        m_valid,
  input  logic [N_ENG-1:0]        m_ready,
  output logic [N_ENG*SAMP_W-1:0] m_data
);
  logic [1:0]  rst_sync;
  logic        rst_core_n;
  logic [15:0] rd_eng [N_ENG];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    logic eng_wr;
    assign eng_wr = bus_wr_en && (bus_addr[ADR_W-1:3] == ENG_B'(e));

    bq_section #(.BATCH(BATCH)) u_sec (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .wr_en  (eng_wr),
      .wr_idx (bus_addr[2:0]),
      .wr_data(bus_wdata),
      .rd_idx (bus_addr[2:0]),
      .rd_data(rd_eng[e]),
      .s_valid(s_valid[e]),
      .s_ready(s_ready[e]),
      .s_data (s_data[e*SAMP_W +: SAMP_W]),
      .m_valid(m_valid[e]),
      .m_ready(m_ready[e]),
      .m_data (m_data[e*SAMP_W +: SAMP_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int e = 0; e < N_ENG; e++)
      if (bus_addr[ADR_W-1:3] == ENG_B'(e)) bus_rdata = rd_eng[e];
  end
endmodule

// File: rtl/bq_checker.sv
module bq_checker #(
  parameter int N_ENG = 2,
  parameter int SW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_ENG-1:0]    s_valid,
  input logic [N_ENG-1:0]    s_ready,
  input logic [N_ENG-1:0]    m_valid,
  input logic [N_ENG-1:0]    m_ready,
  input logic [N_ENG*SW-1:0] m_data
);
  for (genvar e = 0; e < N_ENG; e++) begin : g_chk
    logic [1:0] inflight;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else inflight <= inflight + 2'(s_valid[e] && s_ready[e])
                                - 2'(m_valid[e] && m_ready[e]);
    end

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[e] && !m_ready[e]) |=> (m_valid[e] && $stable(m_data[e*SW +: SW])));

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid[e] && s_ready[e]) |=> !s_ready[e]);

    assert_no_ready_while_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_ready[e] && m_valid[e]));

    assert_out_follows_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid[e] |-> (inflight == 2'd1));

    assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 2'd1);
  end
endmodule

bind dual_biquad_engine bq_checker #(.N_ENG(N_ENG), .SW(bq_pkg::SAMP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_data (m_data)
);

// File: tb/dual_biquad_engine_test.sv
module dual_biquad_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  s_valid;
  logic [1:0]  s_ready;
  logic [31:0] s_data;
  logic [1:0]  m_valid;
  logic [1:0]  m_ready;
  logic [31:0] m_data;

  int checks;
  int fails;
  int mc [2][5];
  int mv1 [2];
  int mv2 [2];
  int samp [2][8];

  dual_biquad_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int s16(input int v);
    return int'($signed(16'(v)));
  endfunction

  function automatic int sat_rnd(input longint a);
    longint r;
    r = (a + 64'sd8192) >>> 14;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic int model_step(input int e, input int x);
    longint acc;
    int w, y;
    acc = longint'(x) * 16384 - longint'(mc[e][3]) * mv1[e] - longint'(mc[e][4]) * mv2[e];
    w   = sat_rnd(acc);
    acc = longint'(mc[e][0]) * w + longint'(mc[e][1]) * mv1[e] + longint'(mc[e][2]) * mv2[e];
    y   = sat_rnd(acc);
    mv2[e] = mv1[e];
    mv1[e] = w;
    return y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int e, input int idx, input int val);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr  = 4'(e * 8 + idx);
    bus_wdata = 16'(val);
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int e, input int idx, output int val);
    @(negedge clk);
    bus_addr = 4'(e * 8 + idx);
    #1;
    val = s16(int'(bus_rdata));
  endtask

  task automatic cfg(input int e, input int b0, input int b1, input int b2,
                     input int a1, input int a2, input int h1, input int h2);
    wr(e, 0, b0); wr(e, 1, b1); wr(e, 2, b2); wr(e, 3, a1); wr(e, 4, a2);
    wr(e, 5, h1); wr(e, 6, h2);
    mc[e][0] = s16(b0); mc[e][1] = s16(b1); mc[e][2] = s16(b2);
    mc[e][3] = s16(a1); mc[e][4] = s16(a2);
    mv1[e] = s16(h1); mv2[e] = s16(h2);
  endtask

  task automatic rand_cfg(input int e);
    cfg(e, s16(int'($urandom)), s16(int'($urandom)), s16(int'($urandom)),
        s16(int'($urandom)), s16(int'($urandom)),
        s16(int'($urandom)), s16(int'($urandom)));
  endtask

  task automatic rand_samples(input int e);
    for (int i = 0; i < 8; i++) samp[e][i] = s16(int'($urandom));
  endtask

  // streams one batch on the engines in mask, checking each output (R1 R2 R11)
  task automatic run_stream(input logic [1:0] mask, input string req);
    int idx [2];
    int got [2];
    int ey  [2];
    bit pend [2];
    int guard;
    for (int e = 0; e < 2; e++) begin
      idx[e] = 0; got[e] = mask[e] ? 0 : 8; pend[e] = 0; ey[e] = 0;
    end
    guard = 0;
    while ((got[0] < 8 || got[1] < 8) && guard < 2000) begin
      @(negedge clk);
      guard++;
      for (int e = 0; e < 2; e++) begin
        if (mask[e]) begin
          if (pend[e]) begin
            idx[e]++;
            s_valid[e] = 1'b0;
            pend[e] = 0;
          end
          if (!s_valid[e] && idx[e] < 8 && ($urandom % 4) != 0) begin
            s_valid[e] = 1'b1;
            s_data[e*16 +: 16] = 16'(samp[e][idx[e]]);
          end
          if (s_valid[e] && s_ready[e]) begin
            pend[e] = 1;
            ey[e] = model_step(e, samp[e][idx[e]]);
          end
          m_ready[e] = (($urandom % 3) != 0);
          if (m_valid[e] && m_ready[e]) begin
            check(req, s16(int'(m_data[e*16 +: 16])), ey[e]);
            got[e]++;
          end
        end
      end
    end
    check({req, " batch completes"}, guard < 2000 ? 1 : 0, 1);
    @(negedge clk);
    s_valid = 2'b00;
    m_ready = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v, saved1, saved2;
    checks = 0;
    fails = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    s_valid = '0; s_data = '0; m_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    check("R12 s_ready", int'(s_ready), 0);
    check("R12 m_valid", int'(m_valid), 0);
    rd(0, 7, v); check("R12 status e0", v, 0);
    rd(1, 0, v); check("R12 b0 e1", v, 0);
    rd(1, 5, v); check("R12 h1 e1", v, 0);

    // R3: register readback of both engines
    rand_cfg(0);
    rand_cfg(1);
    rd(0, 3, v); check("R3 a1 e0", v, mc[0][3]);
    rd(1, 2, v); check("R3 b2 e1", v, mc[1][2]);
    rd(1, 6, v); check("R3 h2 e1", v, mv2[1]);

    // R4 R5 R11: both engines run concurrently
    rand_samples(0); rand_samples(1);
    wr(0, 7, 1); wr(1, 7, 1);
    rd(0, 7, v); check("R5 status busy count 8", v, 'h81);
    @(negedge clk);
    check("R9 ready when busy and idle datapath", int'(s_ready), 3);
    run_stream(2'b11, "R1 R11 dual output");
    rd(0, 7, v); check("R4 R5 status after batch e0", v, 'h02);
    rd(1, 7, v); check("R4 R5 status after batch e1", v, 'h02);
    check("R4 ready low after batch", int'(s_ready), 0);
    rd(0, 5, v); check("R7 h1 after batch e0", v, mv1[0]);
    rd(1, 6, v); check("R7 h2 after batch e1", v, mv2[1]);

    // R7: continuation without rewriting state
    rand_samples(0);
    wr(0, 7, 1);
    run_stream(2'b01, "R7 continued output");

    // R6: writes while busy are ignored
    wr(0, 7, 1);
    wr(0, 0, mc[0][0] ^ 'h1234);
    wr(0, 5, mv1[0] ^ 'h0f0f);
    wr(0, 7, 2);
    wr(0, 7, 1);
    rd(0, 0, v); check("R6 b0 unchanged while busy", v, mc[0][0]);
    rd(0, 5, v); check("R6 h1 unchanged while busy", v, mv1[0]);
    rd(0, 7, v); check("R6 status unchanged while busy", v, 'h81);
    rand_samples(0);
    run_stream(2'b01, "R6 output after ignored writes");

    // R8: clear zeroes history, keeps coefficients
    wr(1, 7, 2);
    mv1[1] = 0; mv2[1] = 0;
    rd(1, 5, v); check("R8 h1 cleared", v, 0);
    rd(1, 6, v); check("R8 h2 cleared", v, 0);
    rd(1, 1, v); check("R8 b1 kept", v, mc[1][1]);
    rd(1, 7, v); check("R8 clear does not start", v, 'h02);
    rand_samples(1);
    wr(1, 7, 1);
    run_stream(2'b10, "R8 output from cleared state");

    // R7: save, disturb, restore, replay
    rd(0, 5, saved1); rd(0, 6, saved2);
    check("R7 saved h1 matches", saved1, mv1[0]);
    rand_samples(0);
    wr(0, 7, 1);
    run_stream(2'b01, "R7 disturbing batch");
    wr(0, 5, saved1); wr(0, 6, saved2);
    mv1[0] = saved1; mv2[0] = saved2;
    wr(0, 7, 1);
    run_stream(2'b01, "R7 replay from restored state");

    // R2: saturation and rounding with direct coefficients
    cfg(1, 'h7fff, 0, 0, 0, 0, 0, 0);
    samp[1] = '{'h7000, -'h7000, 1, -1, 'h3fff, -'h4001, 0, 'h2000};
    begin
      int e0 [8];
      for (int i = 0; i < 8; i++) e0[i] = 0;
      check("R2 model positive saturation", model_step(1, 'h7000), 32767);
      check("R2 model negative saturation", model_step(1, -'h7000), -32768);
      mv1[1] = 0; mv2[1] = 0;
    end
    wr(1, 7, 1);
    run_stream(2'b10, "R2 saturating output");
    cfg(1, 'h2000, 'h2000, 0, 'hc000, 0, 0, 0);
    samp[1] = '{1, -1, 3, -3, 'h7fff, -'h8000, 'h7fff, 2};
    wr(1, 7, 1);
    run_stream(2'b10, "R2 rounding with feedback");

    // random rounds on both engines
    for (int r = 0; r < 6; r++) begin
      rand_cfg(0); rand_cfg(1);
      rand_samples(0); rand_samples(1);
      wr(0, 7, 1); wr(1, 7, 1);
      run_stream(2'b11, "R1 R2 R11 random");
      rd(r % 2, 5, v); check("R7 random history", v, mv1[r % 2]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule